// File: doc/BRIEF.md
# Triple-Redundant Front-End Configuration Register File

This block keeps the settings of a sixteen-channel discriminator front end: one eight-bit threshold per channel, a per-channel timing byte that packs a five-bit delay code and a three-bit pulse-width code, and one mask bit per channel. Every stored bit exists in three separate copies. All consumers, both the configuration outputs and the read port, see only the bitwise two-out-of-three vote, so one upset copy never reaches the front end.

While the correction enable is set, the block repairs any copy that differs from the vote. Every register is compared on every clock cycle, and the repair lands on the next edge. While correction is off, the vote still hides a single upset, but the bad copy is left as it is. A sticky flag records that a disagreement was seen. A saturating counter records how many cycles performed a repair. The host can clear both.

A serial configuration slave drives the block through a plain write strobe with address and data and a separate read address. Read data is registered.

Top module: `tmr_cfg_regs`

## Requirements
- R1: After synchronous reset all thresholds, timing bytes and mask bits are zero, the correction enable reads 1, and the flag and counter are 0.
- R2: A write to a stored register loads all three copies on the same edge. The configuration outputs show the new value after the following edge, and a readback returns it.
- R3: The outputs and reads equal the bitwise majority of the three copies, so an upset in one copy changes neither.
- R4: With correction enabled, a copy that disagrees is rewritten with the voted value on the next edge. A later upset of the same bit in a second copy therefore stays hidden.
- R5: With correction disabled (bit 0 of address 0x22 = 0), the upset copy keeps its wrong value. A second upset of that bit in another copy flips the voted output.
- R6: The flag (port, and bit 0 of address 0x23) is set one edge after any disagreement and holds until a write to 0x23. A disagreement in the clearing cycle keeps it set.
- R7: The counter (port, and address 0x24) rises by one for each cycle in which a repair is made, stops at 255, stays put while correction is disabled, and is zeroed by a write to 0x23.
- R8: Address map: threshold of channel c at 0x00+c; timing byte of channel c at 0x10+c, with delay in bits [4:0] and width in bits [7:5]; mask channels 0–7 at 0x20 and 8–15 at 0x21, bit c%8. On the output buses, channel c sits at thr_o[8c+:8], dly_o[5c+:5], wid_o[3c+:3] and mask_o[c]. Read data appears one edge after the read address.
- R9: Addresses 0x25–0x3F read as zero. Writes to them, or to 0x24, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 6 | Read address |
| rd_data | output | 8 | Registered voted read data |
| thr_o | output | 128 | Voted thresholds, 8 bits per channel |
| dly_o | output | 80 | Voted delay codes, 5 bits per channel |
| wid_o | output | 48 | Voted width codes, 3 bits per channel |
| mask_o | output | 16 | Voted mask bits |
| err_flag_o | output | 1 | Sticky disagreement flag |
| fix_count_o | output | 8 | Saturating repair counter |

## Verification
The bench upsets one copy and then upsets the same bit in a second copy. With correction on, the vote must stay correct, which exposes a scrubber that fails to rewrite the copy, or that rewrites it from the wrong source. With correction off, the vote must flip, which exposes a design that repairs when it should not. More than 255 single upsets check that the counter stops at 255 rather than wrapping to zero. A clear issued while a disagreement persists checks that setting the flag wins over clearing it. Full sweeps over the register map check the field positions and the latency, and that unmapped and read-only addresses are inert, which catches a decoder that aliases them onto stored registers.

// File: rtl/tmr_cfg_pkg.sv
package tmr_cfg_pkg;
  localparam int BYTE_W = 8;
  localparam int N_COPY = 3;

  typedef enum logic [1:0] {
    KIND_STORED,
    KIND_STATUS,
    KIND_COUNT,
    KIND_NONE
  } rd_kind_e;
endpackage

// File: rtl/tmr_bank.sv
// One of the three copies of the register image: host write or scrub load.
module tmr_bank #(
  parameter int              NREG    = 35,
  parameter int              DW      = 8,
  parameter int              IDX_W   = 6,
  parameter logic [NREG*DW-1:0] RST_IMG = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_hit,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [DW-1:0]        wr_data,
  input  logic                 fix_en,
  input  logic [NREG*DW-1:0]   fix_img,
  output logic [NREG*DW-1:0]   q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST_IMG;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (wr_hit && wr_idx == IDX_W'(r))
          q[r*DW +: DW] <= wr_data;
        else if (fix_en)
          q[r*DW +: DW] <= fix_img[r*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/tmr_vote.sv
// Bitwise two-out-of-three vote and disagreement detection.
module tmr_vote #(
  parameter int W = 280
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] v,
  output logic         diff
);
  always_comb begin
    v    = (a & b) | (a & c) | (b & c);
    diff = |((a ^ b) | (a ^ c));
  end
endmodule

// File: rtl/tmr_upset_log.sv
// Sticky disagreement flag and saturating repair counter.
module tmr_upset_log #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seen,
  input  logic             repair,
  input  logic             clr,
  output logic             flag,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)       flag <= 1'b0;
    else if (seen) flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                          count <= '0;
    else if (clr)                     count <= '0;
    else if (repair && count != '1)   count <= count + 1'b1;
  end
endmodule

// File: rtl/tmr_cfg_regs.sv
module tmr_cfg_regs
  import tmr_cfg_pkg::*;
#(
  parameter int N_CH   = 16,
  parameter int TH_W   = 8,
  parameter int DLY_W  = 5,
  parameter int WID_W  = 3,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [BYTE_W-1:0]       wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [BYTE_W-1:0]       rd_data,
  output logic [N_CH*TH_W-1:0]    thr_o,
  output logic [N_CH*DLY_W-1:0]   dly_o,
  output logic [N_CH*WID_W-1:0]   wid_o,
  output logic [N_CH-1:0]         mask_o,
  output logic                    err_flag_o,
  output logic [CNT_W-1:0]        fix_count_o
);
  localparam int DW         = BYTE_W;
  localparam int MASK_BYTES = (N_CH + DW - 1) / DW;
  localparam int TIM_BASE   = N_CH;
  localparam int MASK_BASE  = 2 * N_CH;
  localparam int CTRL_IDX   = MASK_BASE + MASK_BYTES;
  localparam int NREG       = CTRL_IDX + 1;
  localparam int STAT_ADDR  = NREG;
  localparam int CNT_ADDR   = NREG + 1;
  localparam int IMG_W      = NREG * DW;
  localparam int IDX_W      = $clog2(NREG);
  localparam logic [IMG_W-1:0] RST_IMG = IMG_W'(1) << (CTRL_IDX * DW);

  logic               store_hit;
  logic               clr_hit;
  logic [IDX_W-1:0]   wr_idx;
  logic [IMG_W-1:0]   img [N_COPY];
  logic [IMG_W-1:0]   voted;
  logic               mismatch;
  logic               scrub_en;
  rd_kind_e           rd_kind;
  logic [DW-1:0]      rd_next;

  assign store_hit = wr_en && (wr_addr < ADDR_W'(NREG));
  assign clr_hit   = wr_en && (wr_addr == ADDR_W'(STAT_ADDR));
  assign wr_idx    = wr_addr[IDX_W-1:0];

  for (genvar k = 0; k < N_COPY; k++) begin : g_copy
    tmr_bank #(
      .NREG(NREG), .DW(DW), .IDX_W(IDX_W), .RST_IMG(RST_IMG)
    ) u_bank (
      .clk(clk), .rst(rst),
      .wr_hit(store_hit), .wr_idx(wr_idx), .wr_data(wr_data),
      .fix_en(scrub_en), .fix_img(voted),
      .q(img[k])
    );
  end

  tmr_vote #(.W(IMG_W)) u_vote (
    .a(img[0]), .b(img[1]), .c(img[2]),
    .v(voted), .diff(mismatch)
  );

  assign scrub_en = voted[CTRL_IDX*DW];

  tmr_upset_log #(.CNT_W(CNT_W)) u_log (
    .clk(clk), .rst(rst),
    .seen(mismatch), .repair(mismatch && scrub_en), .clr(clr_hit),
    .flag(err_flag_o), .count(fix_count_o)
  );

  // Registered configuration outputs taken from the vote.
  always_ff @(posedge clk) begin
    if (rst) begin
      thr_o  <= '0;
      dly_o  <= '0;
      wid_o  <= '0;
      mask_o <= '0;
    end else begin
      for (int ch = 0; ch < N_CH; ch++) begin
        thr_o[ch*TH_W +: TH_W]   <= voted[ch*DW +: TH_W];
        dly_o[ch*DLY_W +: DLY_W] <= voted[(TIM_BASE+ch)*DW +: DLY_W];
        wid_o[ch*WID_W +: WID_W] <= voted[(TIM_BASE+ch)*DW + DLY_W +: WID_W];
        mask_o[ch]               <= voted[MASK_BASE*DW + ch];
      end
    end
  end

  // Read decode.
  always_comb begin
    if (rd_addr < ADDR_W'(NREG))          rd_kind = KIND_STORED;
    else if (rd_addr == ADDR_W'(STAT_ADDR)) rd_kind = KIND_STATUS;
    else if (rd_addr == ADDR_W'(CNT_ADDR))  rd_kind = KIND_COUNT;
    else                                  rd_kind = KIND_NONE;
  end

  always_comb begin
    case (rd_kind)
      KIND_STORED: rd_next = voted[int'(rd_addr)*DW +: DW];
      KIND_STATUS: rd_next = {{(DW-1){1'b0}}, err_flag_o};
      KIND_COUNT:  rd_next = DW'(fix_count_o);
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/tmr_cfg_regs_chk.sv
module tmr_cfg_regs_chk #(
  parameter int NREG   = 35,
  parameter int DW     = 8,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 8,
  parameter int OUT_W  = 128
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [DW-1:0]       wr_data,
  input logic [NREG*DW-1:0]  img_a,
  input logic [NREG*DW-1:0]  img_b,
  input logic [NREG*DW-1:0]  img_c,
  input logic                mismatch,
  input logic                scrub_en,
  input logic                clr_hit,
  input logic                err_flag,
  input logic [CNT_W-1:0]    fix_count,
  input logic [OUT_W-1:0]    thr_o
);
  logic [ADDR_W-1:0] lw_addr;
  logic [DW-1:0]     lw_data;
  logic [1:0]        age;

  always_ff @(posedge clk) begin
    lw_addr <= wr_addr;
    lw_data <= wr_data;
    if (rst)            age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R2: a write lands in all three copies on one edge
  a_r2_write_all_copies: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr < ADDR_W'(NREG)) |=>
      (img_a[int'(lw_addr)*DW +: DW] == lw_data &&
       img_b[int'(lw_addr)*DW +: DW] == lw_data &&
       img_c[int'(lw_addr)*DW +: DW] == lw_data));

  // R3: with repair on and no recent writes, thresholds do not move
  a_r3_vote_stable: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && scrub_en && !$past(wr_en) && !$past(wr_en, 2)) |-> $stable(thr_o));

  // R4: a disagreement is gone one edge later when repair is on
  a_r4_scrub_repairs: assert property (@(posedge clk) disable iff (rst)
    (mismatch && scrub_en && !wr_en) |=> !mismatch);

  // R6: flag set by a disagreement
  a_r6_flag_sets: assert property (@(posedge clk) disable iff (rst)
    mismatch |=> err_flag);

  // R6: flag holds until cleared
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !clr_hit) |=> err_flag);

  // R7: counter saturates
  a_r7_count_saturates: assert property (@(posedge clk) disable iff (rst)
    (fix_count == '1 && !clr_hit) |=> fix_count == '1);

  // R7: counter frozen while repair is off
  a_r7_count_idle_off: assert property (@(posedge clk) disable iff (rst)
    (!scrub_en && !clr_hit) |=> $stable(fix_count));
endmodule

bind tmr_cfg_regs tmr_cfg_regs_chk #(
  .NREG(NREG), .DW(DW), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .OUT_W(N_CH*TH_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .img_a(img[0]), .img_b(img[1]), .img_c(img[2]),
  .mismatch(mismatch), .scrub_en(scrub_en), .clr_hit(clr_hit),
  .err_flag(err_flag_o), .fix_count(fix_count_o), .thr_o(thr_o)
);

// File: tb/tmr_cfg_regs_bench.sv
`timescale 1ns/1ps
module tmr_cfg_regs_bench;
  localparam int N_CH   = 16;
  localparam int ADDR_W = 6;
  localparam int CNT_W  = 8;
  localparam int NREG   = 35;
  localparam int IMG_W  = NREG * 8;
  localparam int TIMB   = 16;
  localparam int MASKB  = 32;
  localparam int CTRL   = 34;
  localparam int STAT   = 35;
  localparam int CNTA   = 36;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                  rst;
  logic                  wr_en;
  logic [ADDR_W-1:0]     wr_addr;
  logic [7:0]            wr_data;
  logic [ADDR_W-1:0]     rd_addr;
  logic [7:0]            rd_data;
  logic [N_CH*8-1:0]     thr_o;
  logic [N_CH*5-1:0]     dly_o;
  logic [N_CH*3-1:0]     wid_o;
  logic [N_CH-1:0]       mask_o;
  logic                  err_flag_o;
  logic [CNT_W-1:0]      fix_count_o;

  tmr_cfg_regs u_tmr_cfg_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .thr_o(thr_o), .dly_o(dly_o),
    .wid_o(wid_o), .mask_o(mask_o), .err_flag_o(err_flag_o),
    .fix_count_o(fix_count_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int exp_cnt = 0;
  logic [7:0]       mdl [NREG];
  logic [IMG_W-1:0] upset_img;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    rd_addr = ADDR_W'(a);
    @(negedge clk);
    d = int'(rd_data);
  endtask

  task automatic read_all(input string req);
    int d;
    for (int a = 0; a < NREG; a++) begin
      rd(a, d);
      chk(req, d, int'(mdl[a]));
    end
  endtask

  task automatic check_outputs(input string req);
    for (int ch = 0; ch < N_CH; ch++) begin
      chk(req, int'(thr_o[ch*8 +: 8]), int'(mdl[ch]));
      chk(req, int'(dly_o[ch*5 +: 5]), int'(mdl[TIMB+ch][4:0]));
      chk(req, int'(wid_o[ch*3 +: 3]), int'(mdl[TIMB+ch][7:5]));
      chk(req, int'(mask_o[ch]), int'(mdl[MASKB+ch/8][ch%8]));
    end
  endtask

  // Upsets one bit of one copy, built from the bench's own register image.
  task automatic upset(input int k, input int idx, input int b);
    logic [IMG_W-1:0] v;
    for (int r = 0; r < NREG; r++) v[r*8 +: 8] = mdl[r];
    v[idx*8 + b] = ~v[idx*8 + b];
    @(negedge clk);
    upset_img = v;
    case (k)
      0: force u_tmr_cfg_regs.g_copy[0].u_bank.q = upset_img;
      1: force u_tmr_cfg_regs.g_copy[1].u_bank.q = upset_img;
      default: force u_tmr_cfg_regs.g_copy[2].u_bank.q = upset_img;
    endcase
    #1;
    case (k)
      0: release u_tmr_cfg_regs.g_copy[0].u_bank.q;
      1: release u_tmr_cfg_regs.g_copy[1].u_bank.q;
      default: release u_tmr_cfg_regs.g_copy[2].u_bank.q;
    endcase
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int d;
    int sites [6];
    int bits  [6];
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    for (int r = 0; r < NREG; r++) mdl[r] = 8'h00;
    mdl[CTRL] = 8'h01;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check_outputs("R1");
    chk("R1 flag", int'(err_flag_o), 0);
    chk("R1 count", int'(fix_count_o), 0);
    read_all("R1");
    rd(STAT, d); chk("R1 status", d, 0);
    rd(CNTA, d); chk("R1 count read", d, 0);

    // R2: latency of a threshold write
    wr(0, 8'h5A);
    chk("R2 output before second edge", int'(thr_o[7:0]), 0);
    @(negedge clk);
    chk("R2 output after second edge", int'(thr_o[7:0]), 8'h5A);
    mdl[0] = 8'h5A;

    // R8: sweep every stored register
    for (int ch = 0; ch < N_CH; ch++) begin
      mdl[ch]      = 8'((ch * 37 + 11) & 255);
      mdl[TIMB+ch] = 8'((ch * 53 + 7) & 255);
      wr(ch, mdl[ch]);
      wr(TIMB + ch, mdl[TIMB+ch]);
    end
    mdl[MASKB] = 8'hA5; wr(MASKB, 8'hA5);
    mdl[MASKB+1] = 8'h3C; wr(MASKB + 1, 8'h3C);
    read_all("R2");
    check_outputs("R8");

    // R9: unmapped reads and inert writes
    for (int a = CNTA + 1; a < 64; a++) begin
      rd(a, d); chk("R9 unmapped read", d, 0);
    end
    wr(8'h30, 8'hFF);
    wr(CNTA, 8'hFF);
    read_all("R9");
    rd(CNTA, d); chk("R9 count untouched", d, 0);

    // R3 R4: repair on, two staggered upsets of the same bit
    sites = '{0, 5, 15, TIMB + 9, MASKB + 1, CTRL};
    bits  = '{0, 7, 3, 4, 6, 0};
    for (int s = 0; s < 6; s++) begin
      upset(0, sites[s], bits[s]);
      @(negedge clk);
      exp_cnt++;
      chk("R6 flag after upset", int'(err_flag_o), 1);
      chk("R7 count per repair", int'(fix_count_o), exp_cnt);
      rd(sites[s], d); chk("R3 single upset masked", d, int'(mdl[sites[s]]));
      upset(1, sites[s], bits[s]);
      @(negedge clk);
      exp_cnt++;
      rd(sites[s], d); chk("R4 first copy repaired", d, int'(mdl[sites[s]]));
    end
    check_outputs("R4");
    wr(STAT, 0);
    exp_cnt = 0;
    chk("R6 clear flag", int'(err_flag_o), 0);
    chk("R7 clear count", int'(fix_count_o), 0);

    // R5: repair off
    wr(CTRL, 0); mdl[CTRL] = 8'h00;
    upset(0, 3, 2);
    @(negedge clk);
    chk("R6 flag with repair off", int'(err_flag_o), 1);
    chk("R7 no count with repair off", int'(fix_count_o), 0);
    rd(3, d); chk("R5 vote masks first upset", d, int'(mdl[3]));
    repeat (3) @(negedge clk);
    chk("R6 flag holds", int'(err_flag_o), 1);
    wr(STAT, 0);
    chk("R6 set beats clear", int'(err_flag_o), 1);
    upset(1, 3, 2);
    @(negedge clk);
    rd(3, d); chk("R5 second upset flips vote", d, int'(mdl[3] ^ 8'h04));
    chk("R5 output flipped", int'(thr_o[31:24]), int'(mdl[3] ^ 8'h04));
    chk("R7 count frozen", int'(fix_count_o), 0);
    wr(3, mdl[3]);
    wr(CTRL, 1); mdl[CTRL] = 8'h01;
    wr(STAT, 0);
    chk("R6 flag clears once consistent", int'(err_flag_o), 0);
    rd(3, d); chk("R2 rewrite restores", d, int'(mdl[3]));

    // R7: saturation
    for (int i = 0; i < 260; i++) begin
      upset(2, i % NREG, i % 8);
      @(posedge clk);
      @(posedge clk);
      if (i == 99) begin
        @(negedge clk);
        chk("R7 count midway", int'(fix_count_o), 100);
      end
    end
    @(negedge clk);
    chk("R7 saturated", int'(fix_count_o), 255);
    rd(CNTA, d); chk("R7 count read", d, 255);
    rd(STAT, d); chk("R6 status read", d, 1);
    read_all("R3");
    check_outputs("R3");
    wr(STAT, 0);
    chk("R7 cleared", int'(fix_count_o), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule